// File: doc/BRIEF.md
# DRAM Power-Up Initialization Sequencer

This block sits on the controller side of an asynchronous DRAM and holds the memory out of service after power-up. After a synchronous reset it counts out a long start-up wait in system clock cycles, with every strobe inactive. It then drives a programmable number of dummy refresh cycles on the active-low row strobe, column strobe and write enable. Only after the precharge that follows the last dummy cycle does it raise a ready flag that releases normal traffic.

Each dummy cycle takes one of two refresh styles. The style is picked by an input sampled at the start of that cycle. In the row-only style, just the row strobe pulses low. In the column-first style, the column strobe falls a set number of clocks ahead of the row strobe. The wait length, cycle count, column lead, row active time and precharge time are all parameters.

Top module: `dram_init_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `ras_n`, `cas_n` and `we_n` high and `ready` low, and the start-up wait begins again. This holds whatever the sequencer was doing before.
- R2: Number the cycles after the last reset edge from 0. During cycles 0 to `DELAY_CYCLES-1`, `ras_n` and `cas_n` stay high and `ready` stays low. The first dummy cycle starts in cycle `DELAY_CYCLES`.
- R3: Exactly `INIT_CYCLES` falling edges of `ras_n` occur between the end of reset and the rise of `ready`. None occurs after that.
- R4: A dummy cycle with style 1 (column-first) drives `cas_n` low for `CAS_LEAD` cycles with `ras_n` high. It then drives both low for `RAS_ACTIVE` cycles, and both return high in the same cycle.
- R5: A dummy cycle with style 0 (row-only) drives `ras_n` low for `RAS_ACTIVE` cycles and keeps `cas_n` high for the whole cycle.
- R6: `we_n` is high in every cycle.
- R7: After every dummy cycle, including the last one, all strobes stay high for `PRECHARGE` cycles. The next dummy cycle starts in the cycle right after.
- R8: `style_sel` is sampled only at the clock edge that starts a dummy cycle. Changing it at any other time does not change that cycle's waveform.
- R9: `ready` rises in the cycle right after the final precharge. It stays high with all strobes high until the next reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| style_sel | input | 1 | Refresh style for the next dummy cycle: 0 row-only, 1 column-first |
| ras_n | output | 1 | Active-low row strobe |
| cas_n | output | 1 | Active-low column strobe |
| we_n | output | 1 | Active-low write enable, held inactive |
| ready | output | 1 | High once initialization is complete |

## Verification
The bench toggles the style input at random on every clock. A design that sampled it mid-cycle would then mix the two waveforms inside one dummy cycle, or give a cycle the wrong column lead. Off-by-one errors in the wait, active or precharge counters would move a strobe edge by one cycle against the bench's per-cycle schedule. A cycle counter that stopped one short or ran one long would change the number of row strobe falls before `ready`. A reset applied in the middle of the dummy cycles must restart the full wait. A sequencer that kept its cycle count or phase timer across reset would start strobing early.

// File: rtl/dram_init_pkg.sv
package dram_init_pkg;

    typedef enum logic [2:0] {
        ST_WAIT = 3'd0,
        ST_LEAD = 3'd1,
        ST_ACT  = 3'd2,
        ST_PRE  = 3'd3,
        ST_DONE = 3'd4
    } init_state_e;

    typedef enum logic {
        REF_ROW_ONLY  = 1'b0,
        REF_COL_FIRST = 1'b1
    } ref_style_e;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic we_n;
        logic ready;
    } strobe_s;

    localparam strobe_s STROBES_IDLE = '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, ready: 1'b0};

    // Bits needed to hold values 0..n
    function automatic int cnt_width(input int n);
        int w;
        w = $clog2(n + 1);
        return (w < 1) ? 1 : w;
    endfunction

    function automatic int max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

    function automatic strobe_s decode_strobes(input init_state_e st, input ref_style_e sty);
        strobe_s s;
        s = STROBES_IDLE;
        case (st)
            ST_LEAD: s.cas_n = 1'b0;
            ST_ACT: begin
                s.ras_n = 1'b0;
                s.cas_n = (sty == REF_COL_FIRST) ? 1'b0 : 1'b1;
            end
            ST_DONE: s.ready = 1'b1;
            default: s = STROBES_IDLE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/dis_timer.sv
module dis_timer #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             inc,
    output logic [WIDTH-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            count <= '0;
        end else if (inc) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/dis_strobe_dec.sv
module dis_strobe_dec
    import dram_init_pkg::*;
(
    input  init_state_e state,
    input  ref_style_e  style,
    output strobe_s     strobes
);
    always_comb begin
        strobes = decode_strobes(state, style);
    end
endmodule

// File: rtl/dram_init_seq.sv
module dram_init_seq
    import dram_init_pkg::*;
#(
    parameter int DELAY_CYCLES = 20000,
    parameter int INIT_CYCLES  = 8,
    parameter int CAS_LEAD     = 1,
    parameter int RAS_ACTIVE   = 4,
    parameter int PRECHARGE    = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic style_sel,
    output logic ras_n,
    output logic cas_n,
    output logic we_n,
    output logic ready
);
    localparam int PH_MAX = max4(DELAY_CYCLES, CAS_LEAD, RAS_ACTIVE, PRECHARGE);
    localparam int PH_W   = cnt_width(PH_MAX);
    localparam int CYC_W  = cnt_width(INIT_CYCLES);

    init_state_e      state_q, state_d;
    ref_style_e       style_q;
    logic [PH_W-1:0]  ph_cnt, ph_last;
    logic [CYC_W-1:0] cyc_cnt;
    logic             phase_end, cycle_start, last_cycle, ph_clear, cyc_inc;
    strobe_s          strb;

    // Last count value of the current phase
    always_comb begin
        case (state_q)
            ST_WAIT: ph_last = PH_W'(DELAY_CYCLES - 1);
            ST_LEAD: ph_last = PH_W'(CAS_LEAD - 1);
            ST_ACT:  ph_last = PH_W'(RAS_ACTIVE - 1);
            ST_PRE:  ph_last = PH_W'(PRECHARGE - 1);
            default: ph_last = '0;
        endcase
    end

    assign phase_end   = (ph_cnt == ph_last);
    assign last_cycle  = (cyc_cnt == CYC_W'(INIT_CYCLES - 1));
    assign cycle_start = phase_end && ((state_q == ST_WAIT) ||
                                       ((state_q == ST_PRE) && !last_cycle));
    assign ph_clear    = phase_end || (state_q == ST_DONE);
    assign cyc_inc     = phase_end && (state_q == ST_PRE);

    always_comb begin
        state_d = state_q;
        if (phase_end) begin
            case (state_q)
                ST_WAIT: state_d = style_sel ? ST_LEAD : ST_ACT;
                ST_LEAD: state_d = ST_ACT;
                ST_ACT:  state_d = ST_PRE;
                ST_PRE:  state_d = last_cycle ? ST_DONE : (style_sel ? ST_LEAD : ST_ACT);
                default: state_d = ST_DONE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_WAIT;
            style_q <= REF_ROW_ONLY;
        end else begin
            state_q <= state_d;
            if (cycle_start) begin
                style_q <= style_sel ? REF_COL_FIRST : REF_ROW_ONLY;
            end
        end
    end

    dis_timer #(.WIDTH(PH_W)) u_phase_timer (
        .clk   (clk),
        .rst   (rst),
        .clear (ph_clear),
        .inc   (1'b1),
        .count (ph_cnt)
    );

    dis_timer #(.WIDTH(CYC_W)) u_cycle_counter (
        .clk   (clk),
        .rst   (rst),
        .clear (1'b0),
        .inc   (cyc_inc),
        .count (cyc_cnt)
    );

    dis_strobe_dec u_dec (
        .state   (state_q),
        .style   (style_q),
        .strobes (strb)
    );

    assign ras_n = strb.ras_n;
    assign cas_n = strb.cas_n;
    assign we_n  = strb.we_n;
    assign ready = strb.ready;

    // R1: reset forces idle strobes on the following cycle
    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (ras_n && cas_n && we_n && !ready));

    // R2: nothing moves during the start-up wait
    p_wait_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT) |-> (ras_n && cas_n && !ready));

    // R3: never more dummy cycles than configured
    p_cycle_bound_r3: assert property (@(posedge clk) disable iff (rst)
        cyc_cnt <= CYC_W'(INIT_CYCLES));

    // R3: ready only after the full count of dummy cycles
    p_ready_count_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> (cyc_cnt == CYC_W'(INIT_CYCLES)));

    // R4: column strobe was already low when the row strobe falls with it
    p_cas_leads_r4: assert property (@(posedge clk) disable iff (rst)
        ($fell(ras_n) && !cas_n) |-> !$past(cas_n));

    // R4: column strobe released together with the row strobe
    p_cas_release_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(ras_n) |-> cas_n);

    // R5: row-only cycles keep the column strobe high
    p_row_only_r5: assert property (@(posedge clk) disable iff (rst)
        (!ras_n && style_q == REF_ROW_ONLY) |-> cas_n);

    // R8: latched style holds while a dummy cycle is in progress
    p_style_stable_r8: assert property (@(posedge clk) disable iff (rst)
        ((state_q == ST_ACT) && $past(state_q == ST_ACT)) |-> $stable(style_q));

    // R9: ready is sticky and quiet
    p_ready_hold_r9: assert property (@(posedge clk) disable iff (rst)
        ready |=> ready);
    p_ready_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        ready |-> (ras_n && cas_n));

endmodule

// File: tb/dram_init_seq_tb_top.sv
module dram_init_seq_tb_top;

    localparam int D = 300;
    localparam int N = 8;
    localparam int L = 2;
    localparam int A = 4;
    localparam int P = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic style_sel = 1'b0;
    logic ras_n, cas_n, we_n, ready;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    dram_init_seq #(
        .DELAY_CYCLES (D),
        .INIT_CYCLES  (N),
        .CAS_LEAD     (L),
        .RAS_ACTIVE   (A),
        .PRECHARGE    (P)
    ) dut_i (
        .clk       (clk),
        .rst       (rst),
        .style_sel (style_sel),
        .ras_n     (ras_n),
        .cas_n     (cas_n),
        .we_n      (we_n),
        .ready     (ready)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic bit in_win(input int n, input int s, input int e);
        return (n >= s) && (n < e);
    endfunction

    // R1: apply reset and check idle outputs
    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check(ras_n === 1'b1, "R1", "ras_n in reset", ras_n, 1);
        check(cas_n === 1'b1, "R1", "cas_n in reset", cas_n, 1);
        check(we_n  === 1'b1, "R1", "we_n in reset", we_n, 1);
        check(ready === 1'b0, "R1", "ready in reset", ready, 0);
    endtask

    // mode 0: random style every cycle (R8), 1: all column-first, 2: all row-only
    task automatic run_seq(input int mode, input int limit);
        int nstart, cidx, rs, re, cs, ce, rdy, falls, total, lim;
        bit csty, lsel, pras, eras, ecas, erdy;
        string req;
        nstart = D; cidx = 0; rs = -1; re = -1; cs = -1; ce = -1; rdy = -1;
        falls = 0; csty = 1'b0; lsel = style_sel; pras = 1'b1;
        total = D + N * (L + A + P) + 12;
        lim = (limit > 0) ? limit : total;
        for (int n = 0; n < lim; n++) begin
            @(negedge clk);
            if (n == 0) rst = 1'b0;
            if (n == nstart && cidx < N) begin
                // style taken from the value present at the starting edge (R8)
                csty = lsel;
                rs = n + (csty ? L : 0);
                re = rs + A;
                cs = csty ? n : -1;
                ce = csty ? re : -1;
                nstart = re + P;
                cidx++;
                if (cidx == N) rdy = nstart;
            end
            eras = !in_win(n, rs, re);
            ecas = !in_win(n, cs, ce);
            erdy = (rdy >= 0) && (n >= rdy);
            if (n < D)              req = "R2";
            else if (erdy)          req = "R9";
            else if (!eras || !ecas) req = csty ? "R4/R8" : "R5/R8";
            else                    req = "R7";
            check(ras_n === eras, req, "ras_n", ras_n, eras);
            check(cas_n === ecas, req, "cas_n", cas_n, ecas);
            check(ready === erdy, req, "ready", ready, erdy);
            check(we_n === 1'b1, "R6", "we_n", we_n, 1);
            if (pras && ras_n === 1'b0) falls++;
            pras = ras_n;
            case (mode)
                1:       style_sel = 1'b1;
                2:       style_sel = 1'b0;
                default: style_sel = 1'($urandom % 2);
            endcase
            lsel = style_sel;
        end
        if (limit <= 0) begin
            check(falls == N, "R3", "row strobe falls before ready", falls, N);
        end
    endtask

    initial begin
        void'($urandom(32'd7341));
        repeat (3) @(negedge clk);
        check(ras_n === 1'b1 && cas_n === 1'b1 && ready === 1'b0, "R1",
              "initial reset idle", {ras_n, cas_n, ready}, 3'b110);
        run_seq(0, 0);
        do_reset();
        run_seq(1, 0);
        do_reset();
        run_seq(2, 0);
        do_reset();
        run_seq(0, D + 15);     // abort mid-initialization
        do_reset();
        run_seq(0, 0);          // full restart after mid-sequence reset
        do_reset();
        run_seq(0, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule